// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Core

This block keeps the time of day and the calendar date in packed BCD. The resolution is one hundredth of a second and the clock runs on 24 hours. A one-cycle `tick_i` pulse drives it. The parameter `TICK_DIV` sets how many tick pulses make one hundredth, so a 100 Hz strobe uses `TICK_DIV = 1` and a faster prescaled oscillator strobe uses a larger value. The block carries the date through months of 28, 29, 30 and 31 days and through the year. At the end of a century it can toggle a century flag.

Two copies of the time are kept:
- The running copy counts continuously.
- The visible copy is what the register port returns.

The visible copy follows the running copy one cycle later. It stops following in two cases:
- A bus front-end is reading the clock locations. Reads are then coherent across several bytes.
- A power failure has latched the halt flag. The moment of the failure can then be read out afterwards.

In both cases the running copy keeps counting, so no time is lost.

Register port: `rd_en_i` strobes a read and `wr_en_i` strobes a write, each with an 8-bit address. `rdata_o` decodes combinationally from the visible copy at `addr_i`. The register map is:

| Address | Contents |
|---|---|
| 00h | hundredths |
| 01h | bit 7 run-freeze, bits 6:0 seconds |
| 02h | minutes |
| 03h | bit 7 century flag, bit 6 century-flip enable, bits 5:0 hours |
| 04h | day of week in bits 2:0, range 1–7 |
| 05h | date |
| 06h | month |
| 07h | two-digit year |
| 08h | bit 6 halt flag |

Top module: `rtc_cal_core`

## Requirements
- R1: After reset the block reads as follows: 00h–03h read 00, 04h–06h read 01, and 07h–08h read 00.
- R2: Hundredths advance by one for every `TICK_DIV` accepted tick pulses (2 by default). When hundredths go from 99 to 00, seconds advance by one.
- R3: Seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00, each carrying into the next field. Every digit stays a legal BCD digit.
- R4: At the end of a day the date rolls over to 01 and the month advances:
  - Months 04, 06, 09 and 11 roll over after day 30.
  - Month 02 rolls over after day 29 when the year value is divisible by four, and after day 28 otherwise.
  - All other months roll over after day 31.
  - Month 12 wraps to 01 and advances the year.
  - The day of week steps 7 to 1, and otherwise adds one, at each day end.
- R5: The year wraps from 99 to 00. At that moment the century flag (03h bit 7) inverts if the century-flip enable (03h bit 6) is 1, and holds if the enable is 0.
- R6: While the run-freeze bit (01h bit 7) is 1, no field of the time advances. Writing it back to 0 resumes counting.
- R7: A write to 00h loads 00 into hundredths, whatever the data.
- R8: A write to any of 00h–07h restarts the tick divider. The next hundredth step comes `TICK_DIV` ticks after the write.
- R9: A read strobe at 00h–07h freezes the visible copy while the running copy keeps counting. A bus stop, or a read strobe at any address of 08h or above, releases the freeze. The visible copy then catches up.
- R10: `pwr_fail_i` sets the halt flag (08h bit 6), which freezes the visible copy. Writing 08h with bit 6 at 0 clears the flag, and the visible copy then shows the current running time. Writing bit 6 at 1 sets the flag.
- R11: Address 08h reads 0 in every bit other than bit 6. Addresses 09h and above read 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base pulse, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (bus front-end is reading `addr_i`) |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Register write data |
| bus_stop_i | input | 1 | Bus stop event, one cycle wide |
| pwr_fail_i | input | 1 | Power-fail indication |
| rdata_o | output | 8 | Register read data for `addr_i` |

## Verification
The legality checks on the running copy assume that software only writes legal BCD values within each field's range. The stimulus keeps to that assumption: every write loads a valid time such as 23:59:59 or a real date. The freeze properties assume that the visible copy changes only through transfer or direct writes. They therefore exclude cycles that carry a write strobe. The stimulus holds strobes for exactly one cycle and keeps ticks, writes and reads in separate cycles.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned CLK_REGS = 8;
  localparam logic [7:0]  HALT_ADDR = 8'h08;

  typedef struct packed {
    logic       cb;
    logic [7:0] year;
    logic [4:0] month;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
    logic [7:0] hund;
  } cal_time_t;

  localparam cal_time_t RESET_TIME = '{
    cb: 1'b0, year: 8'h00, month: 5'h01, date: 6'h01, dow: 3'd1,
    hour: 6'h00, min: 7'h00, sec: 7'h00, hund: 8'h00
  };

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [6:0] b;
    b = bcd_to_bin(yr);
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [5:0] month_len(input logic [4:0] m, input logic [7:0] yr);
    logic [5:0] r;
    case (m)
      5'h02:                      r = is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction

  // field load for a write to a clock location; hundredths only take zero
  function automatic cal_time_t apply_wr(input cal_time_t t, input logic [2:0] idx,
                                         input logic [7:0] d);
    cal_time_t r;
    r = t;
    case (idx)
      3'd0: r.hund = 8'h00;
      3'd1: r.sec = d[6:0];
      3'd2: r.min = d[6:0];
      3'd3: begin r.cb = d[7]; r.hour = d[5:0]; end
      3'd4: r.dow = d[2:0];
      3'd5: r.date = d[5:0];
      3'd6: r.month = d[4:0];
      default: r.year = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic step_o
);

  generate
    if (DIV <= 1) begin : g_pass
      assign step_o = tick_i && run_i && !clr_i;
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      assign step_o = tick_i && run_i && !clr_i && (cnt_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              cnt_q <= '0;
        else if (clr_i)           cnt_q <= '0;
        else if (tick_i && run_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      step_i,
  input  logic      clk_wr_i,
  input  logic [2:0] widx_i,
  input  logic [7:0] wdata_i,
  output cal_time_t time_o,
  output logic      stop_o,
  output logic      ceb_o
);

  cal_time_t cur_q, nxt;
  logic stop_q, stop_d, ceb_q, ceb_d;
  logic c_sec, c_min, c_hr, c_day, c_mon, c_yr, c_cen;

  always_comb begin
    c_sec = cur_q.hund == 8'h99;
    c_min = c_sec && (cur_q.sec == 7'h59);
    c_hr  = c_min && (cur_q.min == 7'h59);
    c_day = c_hr  && (cur_q.hour == 6'h23);
    c_mon = c_day && (cur_q.date == month_len(cur_q.month, cur_q.year));
    c_yr  = c_mon && (cur_q.month == 5'h12);
    c_cen = c_yr  && (cur_q.year == 8'h99);
  end

  always_comb begin
    nxt    = cur_q;
    stop_d = stop_q;
    ceb_d  = ceb_q;
    if (clk_wr_i) begin
      nxt = apply_wr(cur_q, widx_i, wdata_i);
      if (widx_i == 3'd1) stop_d = wdata_i[7];
      if (widx_i == 3'd3) ceb_d  = wdata_i[6];
    end else if (step_i) begin
      nxt.hund = c_sec ? 8'h00 : bcd_inc(cur_q.hund);
      if (c_sec) nxt.sec = c_min ? 7'h00 : 7'(bcd_inc({1'b0, cur_q.sec}));
      if (c_min) nxt.min = c_hr ? 7'h00 : 7'(bcd_inc({1'b0, cur_q.min}));
      if (c_hr)  nxt.hour = c_day ? 6'h00 : 6'(bcd_inc({2'b0, cur_q.hour}));
      if (c_day) begin
        nxt.dow  = (cur_q.dow == 3'd7) ? 3'd1 : cur_q.dow + 3'd1;
        nxt.date = c_mon ? 6'h01 : 6'(bcd_inc({2'b0, cur_q.date}));
      end
      if (c_mon) nxt.month = c_yr ? 5'h01 : 5'(bcd_inc({3'b0, cur_q.month}));
      if (c_yr)  nxt.year = c_cen ? 8'h00 : bcd_inc(cur_q.year);
      if (c_cen && ceb_q) nxt.cb = ~cur_q.cb;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= RESET_TIME;
      stop_q <= 1'b0;
      ceb_q  <= 1'b0;
    end else begin
      cur_q  <= nxt;
      stop_q <= stop_d;
      ceb_q  <= ceb_d;
    end
  end

  assign time_o = cur_q;
  assign stop_o = stop_q;
  assign ceb_o  = ceb_q;

endmodule

// File: rtl/rtc_user_view.sv
module rtc_user_view
  import rtc_cal_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  cal_time_t int_time_i,
  input  logic      stop_i,
  input  logic      ceb_i,
  input  logic      wr_en_i,
  input  logic      rd_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic      bus_stop_i,
  input  logic      pwr_fail_i,
  output cal_time_t usr_o,
  output logic      hold_o,
  output logic      halt_o,
  output logic [7:0] rdata_o
);

  cal_time_t usr_q, usr_d;
  logic hold_q, halt_q, clk_addr, xfer;

  assign clk_addr = addr_i < 8'(CLK_REGS);
  // transfer blocked by an active read, a held read, or the halt flag
  assign xfer = !hold_q && !halt_q && !pwr_fail_i && !(rd_en_i && clk_addr);

  always_comb begin
    usr_d = usr_q;
    if (xfer)                     usr_d = int_time_i;
    else if (wr_en_i && clk_addr) usr_d = apply_wr(usr_q, addr_i[2:0], wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      usr_q  <= RESET_TIME;
      hold_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      usr_q <= usr_d;
      if (bus_stop_i)   hold_q <= 1'b0;
      else if (rd_en_i) hold_q <= clk_addr;
      if (pwr_fail_i)                           halt_q <= 1'b1;
      else if (wr_en_i && addr_i == HALT_ADDR) halt_q <= wdata_i[6];
    end
  end

  always_comb begin
    case (addr_i)
      8'h00:   rdata_o = usr_q.hund;
      8'h01:   rdata_o = {stop_i, usr_q.sec};
      8'h02:   rdata_o = {1'b0, usr_q.min};
      8'h03:   rdata_o = {usr_q.cb, ceb_i, usr_q.hour};
      8'h04:   rdata_o = {5'b0, usr_q.dow};
      8'h05:   rdata_o = {2'b0, usr_q.date};
      8'h06:   rdata_o = {3'b0, usr_q.month};
      8'h07:   rdata_o = usr_q.year;
      8'h08:   rdata_o = {1'b0, halt_q, 6'b0};
      default: rdata_o = 8'h00;
    endcase
  end

  assign usr_o  = usr_q;
  assign hold_o = hold_q;
  assign halt_o = halt_q;

endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
  import rtc_cal_pkg::*;
#(
  parameter int unsigned TICK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       bus_stop_i,
  input  logic       pwr_fail_i,
  output logic [7:0] rdata_o
);

  cal_time_t int_time, usr_time;
  logic stop_q, ceb_q, hold_q, halt_q, step, clk_wr;

  assign clk_wr = wr_en_i && (addr_i < 8'(CLK_REGS));

  rtc_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (!stop_q),
    .clr_i  (clk_wr),
    .step_o (step)
  );

  rtc_time_chain u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .clk_wr_i (clk_wr),
    .widx_i   (addr_i[2:0]),
    .wdata_i  (wdata_i),
    .time_o   (int_time),
    .stop_o   (stop_q),
    .ceb_o    (ceb_q)
  );

  rtc_user_view u_view (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .int_time_i (int_time),
    .stop_i     (stop_q),
    .ceb_i      (ceb_q),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .bus_stop_i (bus_stop_i),
    .pwr_fail_i (pwr_fail_i),
    .usr_o      (usr_time),
    .hold_o     (hold_q),
    .halt_o     (halt_q),
    .rdata_o    (rdata_o)
  );

endmodule

// File: rtl/rtc_cal_core_chk.sv
module rtc_cal_core_chk
  import rtc_cal_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] addr_i,
  input cal_time_t  int_time,
  input cal_time_t  usr_time,
  input logic       stop_q,
  input logic       hold_q,
  input logic       halt_q
);

  // R3
  fields_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_time.hund[7:4] <= 4'd9) && (int_time.hund[3:0] <= 4'd9) &&
    (int_time.sec <= 7'h59) && (int_time.sec[3:0] <= 4'd9) &&
    (int_time.min <= 7'h59) && (int_time.min[3:0] <= 4'd9) &&
    (int_time.hour <= 6'h23) && (int_time.hour[3:0] <= 4'd9));

  // R6
  stop_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q && !wr_en_i |=> $stable(int_time));

  // R7
  hund_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == 8'h00 |=> int_time.hund == 8'h00);

  // R9
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q && !wr_en_i |=> $stable(usr_time));

  // R10
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q && !wr_en_i |=> $stable(usr_time));

endmodule

bind rtc_cal_core rtc_cal_core_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .int_time (int_time),
  .usr_time (usr_time),
  .stop_q   (stop_q),
  .hold_q   (hold_q),
  .halt_q   (halt_q)
);

// File: tb/rtc_cal_core_bench.sv
module rtc_cal_core_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, tick, wr_en, rd_en, bus_stop, pwr_fail;
  logic [7:0] addr, wdata, rdata;
  int n_chk = 0, n_fail = 0;

  rtc_cal_core u_rtc_cal_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .bus_stop_i(bus_stop), .pwr_fail_i(pwr_fail),
    .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic stop_bus;
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    rd(a, d); stop_bus();
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_cal(input logic [7:0] yr, mo, da, dw, hr, mi, se);
    wr(8'h07, yr); wr(8'h06, mo); wr(8'h05, da); wr(8'h04, dw);
    wr(8'h03, hr); wr(8'h02, mi); wr(8'h01, se); wr(8'h00, 8'h00);
    idle(2);
  endtask

  // one hundredth = 2 ticks; 100 hundredths = 200 ticks
  task automatic roll_day(input string tag, input logic [7:0] yr, mo, da,
                          input logic [7:0] exp_mo, exp_da);
    logic [7:0] v;
    set_cal(yr, mo, da, 8'h03, 8'h23, 8'h59, 8'h59);
    ticks(200);
    peek(8'h06, v); chk({tag, " month"}, v, exp_mo);
    peek(8'h05, v); chk({tag, " date"}, v, exp_da);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    logic [7:0] exp [9] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
    for (int i = 0; i < 9; i++) begin
      peek(8'(i), v); chk($sformatf("R1 reset addr %0d", i), v, exp[i]);
    end
  endtask

  task automatic t_count;
    logic [7:0] v;
    wr(8'h00, 8'h00); ticks(1);
    peek(8'h00, v); chk("R2 half step", v, 8'h00);
    ticks(1);
    peek(8'h00, v); chk("R2 one step", v, 8'h01);
    wr(8'h01, 8'h00); wr(8'h00, 8'h00); ticks(200);
    peek(8'h00, v); chk("R2 hund wrap", v, 8'h00);
    peek(8'h01, v); chk("R2 sec carry", v, 8'h01);
  endtask

  task automatic t_year_end;
    logic [7:0] v;
    set_cal(8'h23, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    ticks(200);
    peek(8'h01, v); chk("R3 sec wrap", v, 8'h00);
    peek(8'h02, v); chk("R3 min wrap", v, 8'h00);
    peek(8'h03, v); chk("R3 hour wrap", v, 8'h00);
    peek(8'h04, v); chk("R4 dow wrap", v, 8'h01);
    peek(8'h05, v); chk("R4 date wrap", v, 8'h01);
    peek(8'h06, v); chk("R4 month wrap", v, 8'h01);
    peek(8'h07, v); chk("R4 year step", v, 8'h24);
  endtask

  task automatic t_months;
    roll_day("R4 leap feb28", 8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
    roll_day("R4 leap feb29", 8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
    roll_day("R4 plain feb28", 8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
    roll_day("R4 apr30", 8'h23, 8'h04, 8'h30, 8'h05, 8'h01);
    roll_day("R4 jan30", 8'h23, 8'h01, 8'h30, 8'h01, 8'h31);
  endtask

  task automatic t_century;
    logic [7:0] v;
    set_cal(8'h99, 8'h12, 8'h31, 8'h01, 8'h63, 8'h59, 8'h59);  // enable=1, flag=0
    ticks(200);
    peek(8'h07, v); chk("R5 year wrap", v, 8'h00);
    peek(8'h03, v); chk("R5 flag flips", v, 8'hC0);
    set_cal(8'h99, 8'h12, 8'h31, 8'h01, 8'hA3, 8'h59, 8'h59);  // enable=0, flag=1
    ticks(200);
    peek(8'h03, v); chk("R5 flag holds", v, 8'h80);
  endtask

  task automatic t_stop;
    logic [7:0] v;
    wr(8'h00, 8'h00); wr(8'h01, 8'h90); ticks(10);
    peek(8'h00, v); chk("R6 frozen hund", v, 8'h00);
    peek(8'h01, v); chk("R6 frozen sec", v, 8'h90);
    wr(8'h01, 8'h10); ticks(2);
    peek(8'h00, v); chk("R6 resumed", v, 8'h01);
  endtask

  task automatic t_hund_wr;
    logic [7:0] v;
    ticks(14);
    wr(8'h00, 8'h45);
    peek(8'h00, v); chk("R7 hund loads zero", v, 8'h00);
  endtask

  task automatic t_div_clr;
    logic [7:0] v;
    wr(8'h00, 8'h00); ticks(1);
    wr(8'h02, 8'h05); ticks(1);
    peek(8'h00, v); chk("R8 phase restart", v, 8'h00);
    ticks(1);
    peek(8'h00, v); chk("R8 step after restart", v, 8'h01);
  endtask

  task automatic t_freeze;
    logic [7:0] v;
    wr(8'h00, 8'h00); idle(2);
    rd(8'h00, v); chk("R9 first read", v, 8'h00);
    ticks(20);
    rd(8'h00, v); chk("R9 held", v, 8'h00);
    stop_bus();
    peek(8'h00, v); chk("R9 stop release", v, 8'h10);
    rd(8'h00, v);
    ticks(4);
    rd(8'h08, v);
    rd(8'h00, v); chk("R9 pointer release", v, 8'h12);
    stop_bus();
  endtask

  task automatic t_halt;
    logic [7:0] v;
    wr(8'h00, 8'h00); idle(2);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk); pwr_fail = 1'b0;
    ticks(20);
    peek(8'h00, v); chk("R10 frozen at failure", v, 8'h00);
    peek(8'h08, v); chk("R10 halt flag set", v, 8'h40);
    wr(8'h08, 8'h00); idle(2);
    peek(8'h00, v); chk("R10 caught up", v, 8'h10);
    peek(8'h08, v); chk("R10 halt cleared", v, 8'h00);
  endtask

  task automatic t_misc;
    logic [7:0] v;
    peek(8'h0A, v); chk("R11 unused addr", v, 8'h00);
    wr(8'h08, 8'hFF);
    peek(8'h08, v); chk("R11 halt only bit", v, 8'h40);
    wr(8'h08, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    bus_stop = 1'b0; pwr_fail = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_count();
    t_year_end();
    t_months();
    t_century();
    t_stop();
    t_hund_wr();
    t_div_clr();
    t_freeze();
    t_halt();
    t_misc();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule